// File: doc/BRIEF.md
# Floating-Point Compare-to-Mask Unit

This block compares two IEEE-754 operands, either both single precision or both double precision, under one of six predicates: equal, not-equal, less-than, less-or-equal, ordered and unordered. It does not return a single condition bit. It returns a result word that is all ones when the predicate holds and all zeros when it does not, so that later bitwise logic can use the word directly as a select mask.

Each predicate has its own rule for NaN operands. The equality and ordering predicates never raise an exception on a NaN. The two relational predicates (less-than and less-or-equal) raise the invalid-operation condition on a NaN. If that condition is unmasked, the result is not written and a trap request goes out instead. A compare is started by a one-cycle valid strobe. All outputs are registered and appear on the next clock cycle.

Predicate codes on `cmp_op`: 0 = EQ, 1 = LT, 2 = LE, 3 = UNORD, 4 = NEQ, 5 = ORD. Codes 6 and 7 are reserved.

Top module: `fpcmp_mask`

## Requirements
- R1: Width and format of the result.
  - A true compare gives all ones and a false compare gives all zeros.
  - With `is_dbl`=1 the operands and the result use all 64 bits.
  - With `is_dbl`=0 the operands are bits 31:0, bits 63:32 of the operands are ignored, and `mask_out[63:32]` is zero.
- R2: For EQ (0) and ORD (5), a NaN in either operand gives all zeros. `inv_flag` stays low, and the result is written even when `inv_mask`=0.
- R3: For NEQ (4) and UNORD (3), a NaN in either operand gives all ones. `inv_flag` stays low, and the result is written even when `inv_mask`=0.
- R4: For LT (1) or LE (2) with a NaN operand and `inv_mask`=1, the result is all zeros and is written, `inv_flag`=1 and `trap_req`=0.
- R5: For LT or LE with a NaN operand and `inv_mask`=0, the response is:
  - `mask_we`=0 and `mask_out` keeps its previous value;
  - `inv_flag`=1 and `trap_req`=1.
- R6: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. The field widths are 8/23 for single and 11/52 for double. Infinities are ordered values, not NaNs.
- R7: Positive zero and negative zero compare equal. EQ and LE are true for them and LT is false.
- R8: Ordered operands are ranked by sign and magnitude. A negative value is below a positive one, and when both are negative the larger magnitude is the smaller value.
- R9: The outputs change one clock after a cycle with `cmp_valid`=1. In a cycle after `cmp_valid`=0, `mask_we`, `inv_flag` and `trap_req` are 0 and `mask_out` holds.
- R10: While `rst_n`=0, every output is zero.
- R11: The reserved predicate codes 6 and 7 give an all-zeros result that is written, with no flag and no trap, even for NaN operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Start a compare this cycle |
| is_dbl | input | 1 | 1 = double precision, 0 = single precision |
| cmp_op | input | 3 | Predicate code |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| inv_mask | input | 1 | 1 = invalid exception masked |
| mask_out | output | 64 | All-ones / all-zeros result |
| mask_we | output | 1 | Result written this cycle |
| inv_flag | output | 1 | Invalid-operation condition seen |
| trap_req | output | 1 | Unmasked invalid exception, request trap |

## Verification
Two functions can fall in the same cycle: raising the invalid flag and suppressing the result write. Both happen only for a relational compare on a NaN with the exception unmasked. The bench provokes this by placing such a compare directly after a compare that writes all ones. It then checks that `inv_flag` and `trap_req` rise together, that `mask_we` stays low, and that `mask_out` still shows the earlier all-ones word. The same NaN compare with the exception masked comes next to it, and there the flag must rise while the zero result is written and no trap is requested.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

   typedef enum logic [2:0] {
      CMP_EQ    = 3'd0,
      CMP_LT    = 3'd1,
      CMP_LE    = 3'd2,
      CMP_UNORD = 3'd3,
      CMP_NEQ   = 3'd4,
      CMP_ORD   = 3'd5
   } cmp_pred_e;

   typedef struct packed {
      logic unord;
      logic eq;
      logic lt;
   } cmp_rel_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int MAG_W = EXP_W + FRAC_W,
   localparam int OP_W  = MAG_W + 1
) (
   input  logic [OP_W-1:0]  op,
   output logic             sgn,
   output logic [MAG_W-1:0] mag,
   output logic             nan,
   output logic             zero
);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   always_comb begin
      sgn    = op[OP_W-1];
      mag    = op[MAG_W-1:0];
      exp_f  = op[MAG_W-1:FRAC_W];
      frac_f = op[FRAC_W-1:0];
      nan    = (&exp_f) && (|frac_f);
      zero   = ~|mag;
   end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
   parameter int MAG_W = 63
) (
   input  logic             sgn_a,
   input  logic             sgn_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   input  logic             zero_a,
   input  logic             zero_b,
   output logic             eq,
   output logic             lt
);

   logic both_zero;
   logic mag_lt;
   logic mag_gt;

   always_comb begin
      both_zero = zero_a && zero_b;
      mag_lt    = mag_a < mag_b;
      mag_gt    = mag_b < mag_a;
      eq        = both_zero || ((sgn_a == sgn_b) && (mag_a == mag_b));
      if (both_zero)
         lt = 1'b0;
      else if (sgn_a != sgn_b)
         lt = sgn_a;
      else if (sgn_a)
         lt = mag_gt;
      else
         lt = mag_lt;
   end

endmodule

// File: rtl/fpcmp_predicate.sv
module fpcmp_predicate
   import fpcmp_pkg::*;
(
   input  logic [2:0] pred,
   input  cmp_rel_t   rel,
   output logic       hit,
   output logic       invalid
);

   always_comb begin
      hit     = 1'b0;
      invalid = 1'b0;
      case (pred)
         CMP_EQ:    hit = !rel.unord && rel.eq;
         CMP_LT: begin
            hit     = !rel.unord && rel.lt;
            invalid = rel.unord;
         end
         CMP_LE: begin
            hit     = !rel.unord && (rel.lt || rel.eq);
            invalid = rel.unord;
         end
         CMP_UNORD: hit = rel.unord;
         CMP_NEQ:   hit = rel.unord || !rel.eq;
         CMP_ORD:   hit = !rel.unord;
         default:   hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/fpcmp_mask.sv
module fpcmp_mask
   import fpcmp_pkg::*;
#(
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11,
   parameter int DP_FRAC_W = 52,
   localparam int SP_MW = SP_EXP_W + SP_FRAC_W,
   localparam int DP_MW = DP_EXP_W + DP_FRAC_W,
   localparam int SP_W  = SP_MW + 1,
   localparam int DP_W  = DP_MW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmp_valid,
   input  logic            is_dbl,
   input  logic [2:0]      cmp_op,
   input  logic [DP_W-1:0] opnd_a,
   input  logic [DP_W-1:0] opnd_b,
   input  logic            inv_mask,
   output logic [DP_W-1:0] mask_out,
   output logic            mask_we,
   output logic            inv_flag,
   output logic            trap_req
);

   generate
      if (SP_W >= DP_W) begin : g_bad_widths
         $error("single format must be narrower than double format");
      end
      if (SP_EXP_W < 2 || DP_EXP_W < 2 || SP_FRAC_W < 1 || DP_FRAC_W < 1) begin : g_bad_fields
         $error("exponent and fraction fields too small");
      end
   endgenerate

   // per-operand classification, one instance per format and operand
   logic [1:0]       sp_sgn, dp_sgn, sp_nan, dp_nan, sp_zero, dp_zero;
   logic [SP_MW-1:0] sp_mag [2];
   logic [DP_MW-1:0] dp_mag [2];
   logic [DP_W-1:0]  opnd   [2];

   assign opnd[0] = opnd_a;
   assign opnd[1] = opnd_b;

   genvar gi;
   generate
      for (gi = 0; gi < 2; gi++) begin : g_opnd
         fpcmp_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
            .op   (opnd[gi][SP_W-1:0]),
            .sgn  (sp_sgn[gi]),
            .mag  (sp_mag[gi]),
            .nan  (sp_nan[gi]),
            .zero (sp_zero[gi])
         );
         fpcmp_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
            .op   (opnd[gi]),
            .sgn  (dp_sgn[gi]),
            .mag  (dp_mag[gi]),
            .nan  (dp_nan[gi]),
            .zero (dp_zero[gi])
         );
      end
   endgenerate

   // precision select onto one shared comparator
   logic [1:0]       sel_sgn, sel_nan, sel_zero;
   logic [DP_MW-1:0] sel_mag [2];

   always_comb begin
      for (int i = 0; i < 2; i++) begin
         sel_sgn[i]  = is_dbl ? dp_sgn[i]  : sp_sgn[i];
         sel_nan[i]  = is_dbl ? dp_nan[i]  : sp_nan[i];
         sel_zero[i] = is_dbl ? dp_zero[i] : sp_zero[i];
         sel_mag[i]  = is_dbl ? dp_mag[i]  : {{(DP_MW-SP_MW){1'b0}}, sp_mag[i]};
      end
   end

   cmp_rel_t rel;
   logic     ord_eq, ord_lt;

   fpcmp_order #(.MAG_W(DP_MW)) u_order (
      .sgn_a  (sel_sgn[0]),
      .sgn_b  (sel_sgn[1]),
      .mag_a  (sel_mag[0]),
      .mag_b  (sel_mag[1]),
      .zero_a (sel_zero[0]),
      .zero_b (sel_zero[1]),
      .eq     (ord_eq),
      .lt     (ord_lt)
   );

   always_comb begin
      rel.unord = |sel_nan;
      rel.eq    = ord_eq;
      rel.lt    = ord_lt;
   end

   logic hit, invalid;

   fpcmp_predicate u_pred (
      .pred    (cmp_op),
      .rel     (rel),
      .hit     (hit),
      .invalid (invalid)
   );

   logic [DP_W-1:0] mask_nxt;
   logic            trap_nxt;

   always_comb begin
      mask_nxt = is_dbl ? {DP_W{hit}} : {{(DP_W-SP_W){1'b0}}, {SP_W{hit}}};
      trap_nxt = invalid && !inv_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_out <= '0;
         mask_we  <= 1'b0;
         inv_flag <= 1'b0;
         trap_req <= 1'b0;
      end else begin
         mask_we  <= cmp_valid && !trap_nxt;
         inv_flag <= cmp_valid && invalid;
         trap_req <= cmp_valid && trap_nxt;
         if (cmp_valid && !trap_nxt)
            mask_out <= mask_nxt;
      end
   end

endmodule

// File: rtl/fpcmp_mask_chk.sv
module fpcmp_mask_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmp_valid,
   input logic        is_dbl,
   input logic [2:0]  cmp_op,
   input logic [63:0] opnd_a,
   input logic [63:0] opnd_b,
   input logic        inv_mask,
   input logic [63:0] mask_out,
   input logic        mask_we,
   input logic        inv_flag,
   input logic        trap_req
);

   // R5
   trap_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> !mask_we);

   // R5
   trap_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> inv_flag);

   // R5
   trap_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> $stable(mask_out));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_valid |=> (!mask_we && !inv_flag && !trap_req));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_valid |=> $stable(mask_out));

   // R1
   mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |-> (mask_out == 64'h0 || mask_out == {64{1'b1}} ||
                   mask_out == 64'h0000_0000_FFFF_FFFF));

   // R4
   masked_flag_writes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_flag && !trap_req) |-> (mask_we && mask_out == 64'h0));

endmodule

bind fpcmp_mask fpcmp_mask_chk u_chk (.*);

// File: tb/fpcmp_mask_test.sv
module fpcmp_mask_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_valid = 1'b0;
   logic        is_dbl = 1'b0;
   logic [2:0]  cmp_op = 3'd0;
   logic [63:0] opnd_a = '0;
   logic [63:0] opnd_b = '0;
   logic        inv_mask = 1'b1;
   logic [63:0] mask_out;
   logic        mask_we, inv_flag, trap_req;

   always #5 clk = ~clk;

   fpcmp_mask uut (.*);

   typedef struct packed {
      logic [3:0]  req;
      logic        dbl;
      logic [2:0]  op;
      logic [63:0] a;
      logic [63:0] b;
      logic        msk;
      logic [63:0] res;
      logic        we;
      logic        flg;
      logic        trp;
   } vec_t;

   localparam logic [63:0] TS = 64'h0000_0000_FFFF_FFFF;
   localparam logic [63:0] TD = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam logic [63:0] Z  = 64'h0;
   localparam int NV = 25;

   localparam vec_t VT [NV] = '{
      '{4'd1, 1'b0, 3'd0, 64'h3F800000, 64'h3F800000, 1'b1, TS, 1'b1, 1'b0, 1'b0}, // R1
      '{4'd1, 1'b0, 3'd0, 64'hDEADBEEF_3F800000, 64'h3F800000, 1'b1, TS, 1'b1, 1'b0, 1'b0}, // R1 upper ignored
      '{4'd1, 1'b0, 3'd0, 64'h3F800000, 64'h40000000, 1'b1, Z, 1'b1, 1'b0, 1'b0}, // R1
      '{4'd8, 1'b0, 3'd1, 64'hBF800000, 64'h3F800000, 1'b1, TS, 1'b1, 1'b0, 1'b0}, // R8
      '{4'd8, 1'b0, 3'd1, 64'hC0000000, 64'hBF800000, 1'b1, TS, 1'b1, 1'b0, 1'b0}, // R8
      '{4'd8, 1'b0, 3'd1, 64'hBF800000, 64'hC0000000, 1'b1, Z, 1'b1, 1'b0, 1'b0}, // R8
      '{4'd8, 1'b0, 3'd2, 64'h40000000, 64'h40000000, 1'b1, TS, 1'b1, 1'b0, 1'b0}, // R8
      '{4'd7, 1'b0, 3'd0, 64'h00000000, 64'h80000000, 1'b1, TS, 1'b1, 1'b0, 1'b0}, // R7
      '{4'd7, 1'b0, 3'd1, 64'h80000000, 64'h00000000, 1'b1, Z, 1'b1, 1'b0, 1'b0}, // R7
      '{4'd7, 1'b0, 3'd2, 64'h80000000, 64'h00000000, 1'b1, TS, 1'b1, 1'b0, 1'b0}, // R7
      '{4'd2, 1'b0, 3'd0, 64'h7FC00000, 64'h3F800000, 1'b0, Z, 1'b1, 1'b0, 1'b0}, // R2
      '{4'd2, 1'b0, 3'd5, 64'h3F800000, 64'h7FC00000, 1'b0, Z, 1'b1, 1'b0, 1'b0}, // R2
      '{4'd3, 1'b0, 3'd4, 64'h7FC00000, 64'h7FC00000, 1'b0, TS, 1'b1, 1'b0, 1'b0}, // R3
      '{4'd6, 1'b0, 3'd3, 64'h3F800000, 64'h7F800001, 1'b0, TS, 1'b1, 1'b0, 1'b0}, // R6 R3
      '{4'd6, 1'b0, 3'd3, 64'h7F800000, 64'h3F800000, 1'b0, Z, 1'b1, 1'b0, 1'b0}, // R6 inf
      '{4'd4, 1'b0, 3'd1, 64'h7FC00000, 64'h3F800000, 1'b1, Z, 1'b1, 1'b1, 1'b0}, // R4
      '{4'd6, 1'b0, 3'd1, 64'h3F800000, 64'h7F800000, 1'b1, TS, 1'b1, 1'b0, 1'b0}, // R6
      '{4'd5, 1'b0, 3'd2, 64'h3F800000, 64'hFFC00000, 1'b0, TS, 1'b0, 1'b1, 1'b1}, // R5 held
      '{4'd1, 1'b1, 3'd1, 64'h3FF0000000000000, 64'h4000000000000000, 1'b0, TD, 1'b1, 1'b0, 1'b0}, // R1
      '{4'd5, 1'b1, 3'd2, 64'h7FF8000000000000, 64'h3FF0000000000000, 1'b0, TD, 1'b0, 1'b1, 1'b1}, // R5
      '{4'd4, 1'b1, 3'd1, 64'h3FF0000000000000, 64'h7FF0000000000001, 1'b1, Z, 1'b1, 1'b1, 1'b0}, // R4
      '{4'd8, 1'b1, 3'd5, 64'hC000000000000000, 64'h4000000000000000, 1'b1, TD, 1'b1, 1'b0, 1'b0}, // R8
      '{4'd6, 1'b1, 3'd0, 64'h7FF0000000000000, 64'h7FF0000000000000, 1'b0, TD, 1'b1, 1'b0, 1'b0}, // R6
      '{4'd11, 1'b0, 3'd6, 64'h3F800000, 64'h3F800000, 1'b1, Z, 1'b1, 1'b0, 1'b0}, // R11
      '{4'd11, 1'b1, 3'd7, 64'h7FF8000000000000, 64'h7FF8000000000000, 1'b0, Z, 1'b1, 1'b0, 1'b0} // R11
   };

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      logic [63:0] held;
      held = '0;
      // R10: reset state
      repeat (3) @(negedge clk);
      check("R10 mask_out", mask_out, 64'h0);
      check("R10 flags", {61'h0, mask_we, inv_flag, trap_req}, 64'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         cmp_valid = 1'b1;
         is_dbl    = VT[i].dbl;
         cmp_op    = VT[i].op;
         opnd_a    = VT[i].a;
         opnd_b    = VT[i].b;
         inv_mask  = VT[i].msk;
         @(negedge clk);
         cmp_valid = 1'b0;
         if (VT[i].we) held = VT[i].res;
         check($sformatf("R%0d vec%0d mask_out", VT[i].req, i), mask_out, held);
         check($sformatf("R%0d vec%0d we/flag/trap", VT[i].req, i),
               {61'h0, mask_we, inv_flag, trap_req},
               {61'h0, VT[i].we, VT[i].flg, VT[i].trp});
      end

      // R9: back-to-back compares, one cycle latency
      @(negedge clk);
      cmp_valid = 1'b1; is_dbl = 1'b0; cmp_op = 3'd4; inv_mask = 1'b1;
      opnd_a = 64'h3F800000; opnd_b = 64'h40000000;
      @(negedge clk);
      check("R9 first of pair", mask_out, TS);
      cmp_op = 3'd0;
      @(negedge clk);
      cmp_valid = 1'b0;
      check("R9 second of pair", mask_out, Z);
      // R9: idle cycle, nothing written, result held
      opnd_a = 64'h7FC00000; cmp_op = 3'd1; inv_mask = 1'b0;
      @(negedge clk);
      check("R9 idle flags", {61'h0, mask_we, inv_flag, trap_req}, 64'h0);
      check("R9 idle hold", mask_out, Z);

      // R10: reset mid-run clears outputs
      cmp_valid = 1'b1; cmp_op = 3'd3;
      @(negedge clk);
      check("R3 pre-reset", mask_out, TS);
      cmp_valid = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      check("R10 mid-run reset", {mask_out[63:3], mask_we, inv_flag, trap_req}, 64'h0);
      rst_n = 1'b1;

      done = 1'b1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

endmodule